// File: doc/BRIEF.md
# Caption Line Bit Clock Recovery

This block recovers the bit timing of the data line carried in the vertical blanking interval of a video signal. Its input is a one-bit data stream that has already been sliced and is sampled by a fast system clock (about 12 MHz). A line gate from the line timing logic marks the window in which the caption line is present. Each field's caption line raises the gate once, and every gated line is decoded on its own.

While it is not locked, the block measures the rising edges of the clock run-in burst inside the gate. It averages their position into a phase for an internal bit divider that places the sampling point at mid-bit, and then declares lock. Once locked, the divider keeps running freely and the phase is held across lines. No further edges move it until a video-change pulse drops the lock. With a valid phase, the block looks for the start pattern in each gated line. It then samples sixteen data bits least significant bit first and delivers two bytes on a valid/ready stream. Each byte carries a flag that reports whether its odd parity failed.

The output stream holds a single byte. A byte stays on `out_byte` with `out_valid` high until `out_ready` is seen high at a clock edge. A byte that completes while the held byte is still waiting is discarded. The consumer must therefore accept each byte within eight bit periods if it is to keep the second byte of a line.

Top module: `caption_clk_recovery`

## Requirements
- R1: After reset, `locked` and `out_valid` are low.
- R2: While unlocked and inside the gate, the first rising edge of `data_in` anchors a grid with a spacing of two bit periods. The offsets of the next four rising edges from that grid are averaged. On the fifth edge, `locked` rises and the bit divider (BIT_CLKS clocks per bit, default 24) is set so that data is sampled BIT_CLKS/2 clocks after each bit boundary.
- R3: While unlocked, a gated line that shows fewer than five rising edges produces no lock and no bytes.
- R4: Once locked, bits sampled inside the gate are only decoded after the start pattern 0,0,1 (oldest first). No byte is emitted for the bits before it.
- R5: The sixteen bits after the start pattern are taken least significant bit first and are delivered as two bytes, the first byte first.
- R6: `out_parity_err` is 1 exactly when the delivered byte (parity in bit 7) holds an even number of ones.
- R7: Lock and phase are kept across lines, so a later line with no run-in burst is still decoded with the held phase.
- R8: A pulse on `video_change` clears `locked` by the next clock. A following line without run-in yields no bytes, and a line with run-in then reacquires at its own phase.
- R9: When the gate falls, reception of the line stops, and a byte that is not yet complete is never emitted.
- R10: While `out_valid` is high and `out_ready` is low, the byte and its flag stay unchanged, and a byte that completes meanwhile is dropped.
- R11: A run-in edge displaced by one clock from the ideal grid still yields correctly decoded bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_gate | input | 1 | High during the caption line window |
| video_change | input | 1 | Pulse that drops the held phase lock |
| data_in | input | 1 | Sliced serial data, sampled by clk |
| locked | output | 1 | Phase is acquired and held |
| out_valid | output | 1 | A decoded byte is on out_byte |
| out_ready | input | 1 | Consumer accepts the byte at this edge |
| out_byte | output | 8 | Decoded byte, parity in bit 7 |
| out_parity_err | output | 1 | Odd parity of out_byte failed |

## Verification
Lock rises one clock after the clock in which the fifth run-in edge is seen, and `video_change` clears it one clock after its pulse. A byte appears on `out_valid` two clocks after the mid-bit sample of its last bit, one clock in the deserializer and one in the output register. The bench reads results only after these delays have passed. A collector samples accepted bytes at falling clock edges, and each line is followed by three bit periods of idle before its bytes, lock state or held output are compared. This margin covers the two-clock output latency with room to spare and keeps every check independent of the exact edge.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    DS_HUNT = 2'd0,
    DS_DATA = 2'd1,
    DS_DONE = 2'd2
  } ds_state_t;
endpackage

// File: rtl/ccr_phase_acq.sv
// Measures run-in rising edges against a grid anchored on the first edge
// and produces a divider load value that puts bit boundaries at the mean.
module ccr_phase_acq #(
  parameter int BIT_CLKS = 24,
  parameter int N_AVG    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        rise,
  output logic                        load,
  output logic [$clog2(BIT_CLKS)-1:0] load_val
);
  localparam int PW = $clog2(BIT_CLKS);
  localparam int GW = $clog2(2 * BIT_CLKS);
  localparam int EW = $clog2(N_AVG + 1) + 1;
  localparam int SH = $clog2(N_AVG);

  logic [GW-1:0] grid_cnt;
  logic [EW-1:0] edge_cnt;
  int            dev_sum;
  int            dev, tot, avg, v;

  always_comb begin
    dev = (int'(grid_cnt) < BIT_CLKS) ? int'(grid_cnt) : int'(grid_cnt) - 2 * BIT_CLKS;
    tot = dev_sum + dev;
    avg = tot >>> SH;
    v   = int'(grid_cnt) - avg + 1;
    if (v < 0) v = v + BIT_CLKS;
    if (v < 0) v = v + BIT_CLKS;
    if (v >= BIT_CLKS) v = v - BIT_CLKS;
    if (v >= BIT_CLKS) v = v - BIT_CLKS;
    if (v >= BIT_CLKS) v = v - BIT_CLKS;
    load     = enable && rise && (edge_cnt == EW'(N_AVG));
    load_val = v[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      grid_cnt <= '0;
      edge_cnt <= '0;
      dev_sum  <= 0;
    end else begin
      grid_cnt <= (grid_cnt == GW'(2 * BIT_CLKS - 1)) ? '0 : grid_cnt + 1'b1;
      if (rise) begin
        if (edge_cnt == '0) begin
          grid_cnt <= GW'(1);
          edge_cnt <= EW'(1);
          dev_sum  <= 0;
        end else if (edge_cnt <= EW'(N_AVG)) begin
          dev_sum  <= tot;
          edge_cnt <= edge_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ccr_bit_timer.sv
// Free-running bit divider; tick marks the mid-bit sampling clock.
module ccr_bit_timer #(
  parameter int BIT_CLKS = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [$clog2(BIT_CLKS)-1:0] load_val,
  output logic                        tick
);
  localparam int PW = $clog2(BIT_CLKS);
  localparam logic [PW-1:0] LAST = PW'(BIT_CLKS - 1);
  localparam logic [PW-1:0] MID  = PW'(BIT_CLKS / 2);

  logic [PW-1:0] bit_pos;

  always_ff @(posedge clk) begin
    if (!rst_n)            bit_pos <= '0;
    else if (load)         bit_pos <= load_val;
    else if (bit_pos == LAST) bit_pos <= '0;
    else                   bit_pos <= bit_pos + 1'b1;
  end

  assign tick = (bit_pos == MID);
endmodule

// File: rtl/ccr_deser.sv
// Start-pattern hunt and LSB-first byte assembly for one gated line.
module ccr_deser
  import ccr_pkg::*;
#(
  parameter int BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       din,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       parity_err
);
  localparam int NB = 8 * BYTES;
  localparam int BW = $clog2(NB);

  ds_state_t     state;
  logic [1:0]    hist;
  logic [6:0]    sh;
  logic [BW-1:0] nbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= DS_HUNT;
      hist       <= 2'b11;
      sh         <= '0;
      nbit       <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (!run) begin
        state <= DS_HUNT;
        hist  <= 2'b11;
        nbit  <= '0;
      end else if (tick) begin
        case (state)
          DS_HUNT: begin
            hist <= {hist[0], din};
            if (hist == 2'b00 && din) begin
              state <= DS_DATA;
              nbit  <= '0;
            end
          end
          DS_DATA: begin
            sh   <= {din, sh[6:1]};
            nbit <= nbit + 1'b1;
            if (nbit[2:0] == 3'd7) begin
              byte_valid <= 1'b1;
              byte_data  <= {din, sh};
            end
            if (nbit == BW'(NB - 1)) state <= DS_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign parity_err = ~^byte_data;
endmodule

// File: rtl/caption_clk_recovery.sv
module caption_clk_recovery #(
  parameter int BIT_CLKS = 24,
  parameter int N_AVG    = 4,
  parameter int BYTES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_gate,
  input  logic       video_change,
  input  logic       data_in,
  output logic       locked,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte,
  output logic       out_parity_err
);
  localparam int PW = $clog2(BIT_CLKS);

  logic          din_q, rise;
  logic          acq_load, tick;
  logic [PW-1:0] acq_val;
  logic          bv, bperr;
  logic [7:0]    bdata;

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= data_in;
  end
  assign rise = data_in & ~din_q;

  ccr_phase_acq #(.BIT_CLKS(BIT_CLKS), .N_AVG(N_AVG)) acq_i (
    .clk(clk), .rst_n(rst_n), .enable(line_gate & ~locked), .rise(rise),
    .load(acq_load), .load_val(acq_val)
  );

  ccr_bit_timer #(.BIT_CLKS(BIT_CLKS)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(acq_load), .load_val(acq_val), .tick(tick)
  );

  ccr_deser #(.BYTES(BYTES)) des_i (
    .clk(clk), .rst_n(rst_n), .run(line_gate & locked), .tick(tick), .din(data_in),
    .byte_valid(bv), .byte_data(bdata), .parity_err(bperr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            locked <= 1'b0;
    else if (video_change) locked <= 1'b0;
    else if (acq_load)     locked <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_byte       <= '0;
      out_parity_err <= 1'b0;
    end else if (bv && (!out_valid || out_ready)) begin
      out_valid      <= 1'b1;
      out_byte       <= bdata;
      out_parity_err <= bperr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       line_gate,
  input logic       video_change,
  input logic       locked,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_parity_err
);
  p_hold_while_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_parity_err)));

  p_unlock_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    video_change |=> !locked);

  p_lock_in_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(line_gate));

  p_bytes_need_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(locked, 2) && $past(line_gate, 2)));
endmodule

bind caption_clk_recovery ccr_checker chk_i (
  .clk(clk), .rst_n(rst_n), .line_gate(line_gate), .video_change(video_change),
  .locked(locked), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte), .out_parity_err(out_parity_err)
);

// File: tb/caption_clk_recovery_tb_top.sv
module caption_clk_recovery_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 24;
  // {phase, first byte, second byte}
  localparam logic [23:0] VEC [6] = '{
    24'h00_80_C1, 24'h05_01_7F, 24'h0B_A5_3C,
    24'h0C_FF_00, 24'h11_52_E3, 24'h17_6B_94
  };

  logic clk = 1'b0, rst_n = 1'b0, line_gate = 1'b0, video_change = 1'b0;
  logic data_in = 1'b0, out_ready = 1'b1;
  logic locked, out_valid, out_parity_err;
  logic [7:0] out_byte;
  int cyc = 0, total = 0, bad = 0, rx_n = 0;
  logic [7:0] rx_b [8];
  logic       rx_e [8];

  caption_clk_recovery dut_i (
    .clk(clk), .rst_n(rst_n), .line_gate(line_gate), .video_change(video_change),
    .data_in(data_in), .locked(locked), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_parity_err(out_parity_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rx_n < 8) begin
      rx_b[rx_n] = out_byte;
      rx_e[rx_n] = out_parity_err;
      rx_n = rx_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_change();
    @(negedge clk) video_change = 1'b1;
    @(negedge clk) video_change = 1'b0;
  endtask

  task automatic send_line(input int ph, input int edges, input logic [7:0] b0,
                           input logic [7:0] b1, input int jit, input int dbits);
    logic [63:0] seq;
    int len;
    seq = '0;
    for (int k = 0; k < 14; k++) seq[k] = (k % 2 == 0) && (k / 2 < edges);
    seq[16] = 1'b1;
    for (int i = 0; i < 16; i++) seq[17 + i] = (i < 8) ? b0[i] : b1[i - 8];
    len = 17 + dbits + ((dbits == 16) ? 2 : 0);
    rx_n = 0;
    @(negedge clk) line_gate = 1'b1;
    repeat (3) @(negedge clk);
    while ((((cyc - ph) % P) + P) % P != 0) @(negedge clk);
    for (int k = 0; k < len; k++)
      for (int c = 0; c < P; c++) begin
        data_in = (k == 4 && c < jit) ? 1'b0 : seq[k];
        @(negedge clk);
      end
    data_in = 1'b0;
    line_gate = 1'b0;
    repeat (3 * P) @(negedge clk);
  endtask

  task automatic chk_pair(input string req, input logic [7:0] b0, input logic [7:0] b1);
    chk(req, "byte count", rx_n, 2);
    chk(req, "first byte", int'(rx_b[0]), int'(b0));
    chk(req, "second byte", int'(rx_b[1]), int'(b1));
    chk("R6", "first parity flag", int'(rx_e[0]), int'(~^b0));
    chk("R6", "second parity flag", int'(rx_e[1]), int'(~^b1));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "locked in reset", int'(locked), 0);
    chk("R1", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "locked after reset", int'(locked), 0);

    // table walk: reacquire at each phase, decode both bytes
    for (int i = 0; i < 6; i++) begin
      pulse_change();
      chk("R8", "lock cleared by change", int'(locked), 0);
      send_line(int'(VEC[i][23:16]), 7, VEC[i][15:8], VEC[i][7:0], 0, 16);
      chk("R2", "locked after run-in", int'(locked), 1);
      chk("R4", "only bytes after start", rx_n, 2);
      chk_pair("R5", VEC[i][15:8], VEC[i][7:0]);
    end

    // R7: held phase, no run-in
    send_line(23, 0, 8'h3B, 8'hC8, 0, 16);
    chk_pair("R7", 8'h3B, 8'hC8);

    // R8: change then line without run-in, then reacquire at new phase
    pulse_change();
    send_line(23, 0, 8'h01, 8'h00, 0, 16);
    chk("R8", "no bytes after change", rx_n, 0);
    chk("R8", "still unlocked", int'(locked), 0);
    send_line(7, 7, 8'h9E, 8'h46, 0, 16);
    chk_pair("R8", 8'h9E, 8'h46);

    // R3: too few edges, and none at all
    pulse_change();
    send_line(7, 3, 8'h00, 8'h00, 0, 16);
    chk("R3", "no bytes with three run-in edges", rx_n, 0);
    chk("R3", "no lock with three run-in edges", int'(locked), 0);
    send_line(7, 0, 8'h00, 8'h00, 0, 16);
    chk("R3", "no bytes without edges", rx_n, 0);

    // R9: gate falls after twelve data bits
    send_line(10, 7, 8'hD3, 8'h2A, 0, 12);
    chk("R9", "one byte before gate fall", rx_n, 1);
    chk("R9", "completed byte", int'(rx_b[0]), 8'hD3);

    // R10: stalled consumer keeps first byte, drops second
    out_ready = 1'b0;
    send_line(10, 0, 8'h6D, 8'h92, 0, 16);
    chk("R10", "valid held while stalled", int'(out_valid), 1);
    chk("R10", "held byte", int'(out_byte), 8'h6D);
    chk("R10", "nothing accepted while stalled", rx_n, 0);
    @(negedge clk) out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "single byte after release", rx_n, 1);
    chk("R10", "released byte", int'(rx_b[0]), 8'h6D);

    // R11: one run-in edge a clock late
    pulse_change();
    send_line(15, 7, 8'hE7, 8'h15, 1, 16);
    chk_pair("R11", 8'hE7, 8'h15);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule